// File: doc/BRIEF.md
# Indirect Buffer RAM Access Port

This block lets a host bus reach a 2048-byte on-chip buffer through a small window of three byte-wide registers: a pointer-high register, a pointer-low register and a data register. Together the two pointer registers form an 11-bit address. The pointer-high register also holds a direction flag and an auto-advance flag. In read direction, a write to the pointer-low register starts a single fetch of the addressed byte into the data register. After that, data-register reads can step through the buffer without any more pointer writes. In write direction, each byte written to the data register is stored at the pointer.

The buffer has a single synchronous port with one cycle of read latency. The host shares that port with a network-side requester. The network side always wins a contested cycle. A host write or fetch that is held off stays pending, and `hostBusy` stays high until every pending host operation has finished. Software polls `hostBusy` before its next data-register access.

Top module: `ramAccessPort`

## Requirements
- R1: After reset the pointer is 0x000, both flags are clear, `hostBusy` is low, and both pointer registers read back 0x00.
- R2: Register select 0 is pointer-high. Bit 7 is the read-direction flag, bit 6 is the auto-advance flag, and bits 2:0 are address bits 10:8. Bits 5:3 always read as 0. Select 3 reads 0x00.
- R3: Register select 1 is pointer-low and holds address bits 7:0. Writing it replaces only those bits.
- R4: Writing pointer-low while the read flag is set loads the byte at the new pointer into the data register (select 2). The byte is readable after the second rising edge following the write strobe, and `hostBusy` is high for exactly those two cycles when the network side is idle. With the read flag clear, the write starts no fetch and `hostBusy` stays low.
- R5: A data-register write stores the byte at the pointer value current at the strobe. The store completes one edge later, and `hostBusy` is high for that one cycle.
- R6: With auto-advance set, each data-register access (read or write) adds one to the pointer, wrapping from 0x7FF to 0x000. Pointer-register accesses never advance it.
- R7: With auto-advance and read direction both set, a data-register read returns the current byte and starts a fetch of the next address. The fetched byte is readable two edges later.
- R8: With auto-advance clear, data-register reads leave the pointer unchanged, return the same byte each time, and leave `hostBusy` low.
- R9: `netGnt` equals `netReq` in the same cycle. A granted network write stores at that edge. A granted network read presents the byte on `netRdata` in the following cycle. While `netReq` is high, a pending host write or fetch waits and `hostBusy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 2 | Register select: 0 pointer-high, 1 pointer-low, 2 data |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Selected register, combinational on `hostSel` |
| hostBusy | output | 1 | A host write or fetch is still outstanding |
| netReq | input | 1 | Network-side request for the buffer port |
| netWe | input | 1 | Network request is a write |
| netAddr | input | 11 | Network-side address |
| netWdata | input | 8 | Network-side write data |
| netGnt | output | 1 | Network request granted this cycle |
| netRdata | output | 8 | Network read data, valid the cycle after a granted read |

## Verification
A data write lands in the buffer one edge after its strobe. A fetch lands in the data register two edges after the strobe that starts it, plus one edge for every cycle the network side holds the port. Network read data appears one edge after its grant. Stimulus changes 1 ns after a rising edge. The behavioural reference model advances at each rising edge, and outputs are compared at the following falling edge, so every comparison falls in the cycle its result is due. Bytes that were never written, and the data register before its first load, are tracked as unknown and left out of the comparison.

// File: rtl/rap_pkg.sv
package rap_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_HI = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_t;

  typedef struct packed {
    logic ldPtrHi;
    logic ldPtrLo;
    logic ldDataHost;
    logic incPtr;
    logic ramHostEn;
    logic ramHostWe;
    logic ldDataRam;
  } strobes_t;
endpackage

// File: rtl/rapCtrl.sv
module rapCtrl
  import rap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  regSel_t  hostSel,
  input  logic     hostWr,
  input  logic     hostRd,
  input  logic     netReq,
  input  logic     readMode,
  input  logic     autoInc,
  output strobes_t strb,
  output logic     busy
);
  logic pendWrite, pendFetch, inFlight;
  logic doWrite, doFetch, dataAcc, startFetch;

  assign dataAcc    = (hostWr || hostRd) && (hostSel == SEL_DATA);
  assign doWrite    = !netReq && pendWrite;
  assign doFetch    = !netReq && !pendWrite && pendFetch;
  assign startFetch = readMode && ((hostWr && hostSel == SEL_PTR_LO) ||
                                   (hostRd && hostSel == SEL_DATA && autoInc));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWrite <= 1'b0;
      pendFetch <= 1'b0;
      inFlight  <= 1'b0;
    end else begin
      pendWrite <= (pendWrite && !doWrite) || (hostWr && hostSel == SEL_DATA);
      pendFetch <= (pendFetch && !doFetch) || startFetch;
      inFlight  <= doFetch;
    end
  end

  always_comb begin
    strb            = '0;
    strb.ldPtrHi    = hostWr && hostSel == SEL_PTR_HI;
    strb.ldPtrLo    = hostWr && hostSel == SEL_PTR_LO;
    strb.ldDataHost = hostWr && hostSel == SEL_DATA;
    strb.incPtr     = dataAcc && autoInc;
    strb.ramHostEn  = doWrite || doFetch;
    strb.ramHostWe  = doWrite;
    strb.ldDataRam  = inFlight;
  end

  assign busy = pendWrite || pendFetch || inFlight;

  // R5
  write_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendWrite && !netReq && !hostWr |=> !pendWrite);
  // R4
  fetch_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendFetch && !pendWrite && !netReq |=> inFlight);
  // R9
  net_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    netReq && pendFetch |=> pendFetch && busy);
  // R8
  no_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !autoInc && hostRd && !pendFetch && !hostWr |=> !pendFetch);
endmodule

// File: rtl/rapRam.sv
module rapRam #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q <= mem[addr];
    end
  end
endmodule

// File: rtl/rapDatapath.sv
module rapDatapath
  import rap_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  regSel_t           hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              readMode,
  output logic              autoInc,
  input  logic              netReq,
  input  logic              netWe,
  input  logic [ADDR_W-1:0] netAddr,
  input  logic [DATA_W-1:0] netWdata,
  output logic [DATA_W-1:0] netRdata
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int PAD_W = DATA_W - 2 - HI_W;

  logic [ADDR_W-1:0] ptr, wrAddr, ramAddr;
  logic [DATA_W-1:0] dataReg, ramQ, ptrHiView;
  logic              ramEn, ramWe;
  logic              unusedHiBits;

  assign unusedHiBits = ^hostWdata[DATA_W-3:HI_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      readMode <= 1'b0;
      autoInc  <= 1'b0;
    end else begin
      if (strb.ldPtrHi) begin
        readMode            <= hostWdata[DATA_W-1];
        autoInc             <= hostWdata[DATA_W-2];
        ptr[ADDR_W-1:DATA_W] <= hostWdata[HI_W-1:0];
      end else if (strb.ldPtrLo) begin
        ptr[DATA_W-1:0] <= hostWdata;
      end else if (strb.incPtr) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.ldDataHost) begin
      dataReg <= hostWdata;
      wrAddr  <= ptr;
    end else if (strb.ldDataRam) begin
      dataReg <= ramQ;
    end
  end

  assign ramEn   = netReq || strb.ramHostEn;
  assign ramWe   = netReq ? netWe : strb.ramHostWe;
  assign ramAddr = netReq ? netAddr : (strb.ramHostWe ? wrAddr : ptr);

  rapRam #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRam (
    .clk  (clk),
    .en   (ramEn),
    .we   (ramWe),
    .addr (ramAddr),
    .wdata(netReq ? netWdata : dataReg),
    .q    (ramQ)
  );

  assign netRdata  = ramQ;
  assign ptrHiView = {readMode, autoInc, {PAD_W{1'b0}}, ptr[ADDR_W-1:DATA_W]};

  always_comb begin
    unique case (hostSel)
      SEL_PTR_HI: hostRdata = ptrHiView;
      SEL_PTR_LO: hostRdata = ptr[DATA_W-1:0];
      SEL_DATA:   hostRdata = dataReg;
      default:    hostRdata = '0;
    endcase
  end

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incPtr && !strb.ldPtrHi && !strb.ldPtrLo && (&ptr) |=> ptr == '0);
  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.incPtr && !strb.ldPtrHi && !strb.ldPtrLo |=> $stable(ptr));
endmodule

// File: rtl/ramAccessPort.sv
module ramAccessPort
  import rap_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostBusy,
  input  logic              netReq,
  input  logic              netWe,
  input  logic [ADDR_W-1:0] netAddr,
  input  logic [DATA_W-1:0] netWdata,
  output logic              netGnt,
  output logic [DATA_W-1:0] netRdata
);
  strobes_t strb;
  regSel_t  sel;
  logic     readMode, autoInc;

  assign sel    = regSel_t'(hostSel);
  assign netGnt = netReq;

  rapCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostSel (sel),
    .hostWr  (hostWr),
    .hostRd  (hostRd),
    .netReq  (netReq),
    .readMode(readMode),
    .autoInc (autoInc),
    .strb    (strb),
    .busy    (hostBusy)
  );

  rapDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hostSel  (sel),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .readMode (readMode),
    .autoInc  (autoInc),
    .netReq   (netReq),
    .netWe    (netWe),
    .netAddr  (netAddr),
    .netWdata (netWdata),
    .netRdata (netRdata)
  );
endmodule

// File: tb/sim_ramAccessPort.sv
`timescale 1ns/1ps
module sim_ramAccessPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostSel = 2'd2;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostWdata = '0, hostRdata;
  logic        hostBusy;
  logic        netReq = 1'b0, netWe = 1'b0;
  logic [10:0] netAddr = '0;
  logic [7:0]  netWdata = '0, netRdata;
  logic        netGnt;

  int compared = 0, mismatched = 0, cycles = 0;

  ramAccessPort u0 (.*);

  always #2 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int   mPtr, wA, fetchV, mData, mNetQ;
  bit   mRd, mAi, pW, pF, inFl, netQv, netQok, mDataOk;
  byte  mem [2048];
  bit   memOk [2048];
  bit   fetchOk;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPtr = 0; mRd = 0; mAi = 0; pW = 0; pF = 0; inFl = 0; netQv = 0;
    end else begin
      if (inFl) begin mData = fetchV; mDataOk = fetchOk; inFl = 0; end
      netQv = 0;
      if (netReq) begin
        if (netWe) begin mem[netAddr] = netWdata; memOk[netAddr] = 1; end
        else begin mNetQ = mem[netAddr]; netQok = memOk[netAddr]; netQv = 1; end
      end else if (pW) begin
        mem[wA] = mData[7:0]; memOk[wA] = mDataOk; pW = 0;
      end else if (pF) begin
        fetchV = mem[mPtr]; fetchOk = memOk[mPtr]; pF = 0; inFl = 1;
      end
      if (hostWr) begin
        case (hostSel)
          2'd0: begin mRd = hostWdata[7]; mAi = hostWdata[6];
                  mPtr = (mPtr & 8'hFF) | (int'(hostWdata[2:0]) << 8); end
          2'd1: begin mPtr = (mPtr & 11'h700) | hostWdata; if (mRd) pF = 1; end
          2'd2: begin mData = hostWdata; mDataOk = 1; wA = mPtr; pW = 1;
                  if (mAi) mPtr = (mPtr + 1) & 11'h7FF; end
          default: ;
        endcase
      end
      if (hostRd && hostSel == 2'd2 && mAi) begin
        mPtr = (mPtr + 1) & 11'h7FF;
        if (mRd) pF = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      int exp;
      case (hostSel)
        2'd0: exp = {mRd, mAi, 3'b000, 3'(mPtr >> 8)};
        2'd1: exp = mPtr & 8'hFF;
        2'd2: exp = mData & 8'hFF;
        default: exp = 0;
      endcase
      if (hostSel != 2'd2) check(hostSel == 0 ? "R2 ptrHi" : (hostSel == 1 ? "R3 ptrLo" : "R2 sel3"), hostRdata, exp);
      else if (mDataOk) check("R7 dataReg", hostRdata, exp);
      check("R4 hostBusy", hostBusy, int'(pW || pF || inFl));
      check("R9 netGnt", netGnt, netReq);
      if (netQv && netQok) check("R9 netRdata", netRdata, mNetQ & 8'hFF);
    end
    if (cycles > 100000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic waitIdle();
    while (hostBusy) step();
  endtask

  task automatic hWrite(logic [1:0] sel, logic [7:0] d);
    step(); hostSel = sel; hostWr = 1; hostWdata = d;
    step(); hostWr = 0; hostSel = 2'd2;
  endtask

  task automatic hRead(logic [1:0] sel, output logic [7:0] d);
    step(); hostSel = sel; hostRd = 1;
    #1 d = hostRdata;
    step(); hostRd = 0; hostSel = 2'd2;
  endtask

  task automatic setPtr(logic [7:0] hi, logic [7:0] lo);
    hWrite(2'd0, hi); hWrite(2'd1, lo); waitIdle();
  endtask

  initial begin
    logic [7:0] v;
    int seed = 7;
    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    hRead(2'd0, v); check("R1 ptrHi after reset", v, 8'h00);
    hRead(2'd1, v); check("R1 ptrLo after reset", v, 8'h00);
    check("R1 busy after reset", hostBusy, 0);

    // R2 layout, pad bits read as zero
    hWrite(2'd0, 8'hFF); hRead(2'd0, v); check("R2 ptrHi readback", v, 8'hC7);
    hRead(2'd3, v); check("R2 sel3 reads zero", v, 8'h00);
    // R3 low byte only
    hWrite(2'd0, 8'h45); hWrite(2'd1, 8'h9A); waitIdle();
    hRead(2'd1, v); check("R3 ptrLo readback", v, 8'h9A);
    hRead(2'd0, v); check("R3 ptrHi kept", v, 8'h45);

    // R5 R6 writes with auto-advance crossing the wrap
    setPtr(8'h47, 8'hFE);
    hWrite(2'd2, 8'hA1); check("R5 busy one cycle", hostBusy, 1); step();
    check("R5 busy clear", hostBusy, 0);
    hWrite(2'd2, 8'hB2); waitIdle();
    hWrite(2'd2, 8'hC3); waitIdle();
    hRead(2'd0, v); check("R6 ptrHi after wrap", v, 8'h40);
    hRead(2'd1, v); check("R6 ptrLo after wrap", v, 8'h01);

    // R4 no fetch in write direction
    hWrite(2'd1, 8'h10); check("R4 no fetch busy", hostBusy, 0);

    // R4 R7 read direction with auto-advance
    hWrite(2'd0, 8'hC7); hWrite(2'd1, 8'hFE);
    check("R4 busy cycle 1", hostBusy, 1); step();
    check("R4 busy cycle 2", hostBusy, 1); step();
    check("R4 busy clear", hostBusy, 0);
    hRead(2'd2, v); check("R4 R7 first byte", v, 8'hA1); waitIdle();
    hRead(2'd2, v); check("R7 second byte", v, 8'hB2); waitIdle();
    hRead(2'd2, v); check("R7 wrapped byte", v, 8'hC3); waitIdle();

    // R8 no auto-advance
    setPtr(8'h87, 8'hFF);
    hRead(2'd2, v); check("R8 read one", v, 8'hB2);
    check("R8 busy stays low", hostBusy, 0);
    hRead(2'd2, v); check("R8 read two", v, 8'hB2);
    hRead(2'd1, v); check("R8 ptr unchanged", v, 8'hFF);

    // R9 network holds the port while a fetch waits
    hWrite(2'd0, 8'h81);
    step(); hostSel = 2'd1; hostWr = 1; hostWdata = 8'h23;
    netReq = 1; netWe = 1; netAddr = 11'h123; netWdata = 8'h5E;
    step(); hostWr = 0; hostSel = 2'd2;
    step(); check("R9 busy while stalled", hostBusy, 1);
    netReq = 0; netWe = 0;
    waitIdle();
    hRead(2'd2, v); check("R9 fetch after stall", v, 8'h5E);
    step(); netReq = 1; netAddr = 11'h7FE;
    step(); netReq = 0; #1 check("R9 net read", netRdata, 8'hA1);

    // mixed traffic checked by the model every cycle
    for (int i = 0; i < 300; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
      setPtr({2'b01, 3'b000, 3'(seed >> 8)}, 8'(seed >> 12));
      hWrite(2'd2, 8'(seed >> 20)); waitIdle();
      if (seed[3]) begin
        step(); netReq = 1; netWe = seed[4]; netAddr = 11'(seed >> 5); netWdata = 8'(seed >> 16);
        step(); netReq = 0;
      end
      setPtr({2'b11, 3'b000, 3'(seed >> 8)}, 8'(seed >> 12));
      if (seed[5]) begin step(); netReq = 1; netWe = 0; step(); netReq = 0; end
      waitIdle();
      hRead(2'd2, v); waitIdle();
      hRead(2'd2, v); waitIdle();
    end

    repeat (4) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule